// File: doc/BRIEF.md
# Four-Tributary Justified Frame Multiplexer

This block is the transmit side of a second-order digital multiplex. It takes four serial tributaries that are not locked to the aggregate clock and interleaves them bit by bit into an 848-bit aggregate frame. That frame is divided into four 212-bit sets. Each tributary first goes into its own 16-bit elastic buffer. When a tributary's buffer runs low, the block sends that tributary a positive justification once per frame, so the aggregate rate (8448 kbit/s nominal) can absorb tributaries that run near 2048 kbit/s but not exactly at it.

A frame-position counter advances one bit on each cycle in which the reference enable is high. In each such cycle the block emits one aggregate bit. That bit can be the alignment word, the alarm bit, the national bit, a justification-control bit, a justification-opportunity bit or an information bit. The block sends the justification control three times per frame, so the far end can decide by majority vote. The first copy can carry four bits of user data instead of control bits. Idle and unframed test outputs and a corrupted alignment word let the far-end deframer be tested.

Top module: `trib_jmux`

## Requirements
- R1: While `rst_n` is low, `agg_data`, `frame_start` and every bit of `trib_err` are 0. After reset the frame position is 0, every buffer is empty and not primed, idle code 0 applies and the alignment word is not corrupted.
- R2: The frame position advances only on cycles with `ref_en` high and wraps after 848 enabled cycles. Each emitted bit appears on `agg_data` one cycle after its enabled edge and holds until the next enabled edge. `frame_start` is high for exactly the one cycle in which position 0 is presented.
- R3: Positions 0..9 carry the alignment word 1111010000, first bit first. Position 10 carries `alarm_in` and position 11 carries `nat_in`, both sampled at the emitting edge.
- R4: Information bits fill positions 12..211, 216..423, 428..635 and 644..847. Each one belongs to tributary (position mod 4), and each tributary's bits leave in the order they were written.
- R5: At the enabled edge of position 0, a tributary is marked for justification if its buffer holds fewer than 8 bits. Its control bits at positions 212+i, 424+i and 636+i are then 1, and its opportunity bit at 640+i is 0 and consumes no buffer bit. An unmarked tributary sends 0 control bits and carries its next data bit in the opportunity.
- R6: If `rch_en` is high at the enabled edge of position 0, positions 212..215 carry `rch_data[i]` (sampled at that edge) for tributary i in place of the first control copy. The other two copies are unchanged.
- R7: A pulse on `idle_set` latches `idle_cmd`, which applies from the next enabled edge. Code 1 sends all information and opportunity bits as 0 and code 2 sends them as 1. Code 3 sends every bit as 0 and code 4 sends every bit as 1. Codes 0, 5, 6 and 7 are normal operation. Codes 1 to 4 read no buffer bits.
- R8: A pulse on `fas_set` latches `fas_bad`. While the latched value is 1, positions 0..9 carry the complement of the alignment word.
- R9: Each buffer becomes primed at the first edge at which it already holds at least 4 bits. Until then, its information and opportunity slots send 0 and read nothing.
- R10: A write (`trib_valid[i]` high) to a buffer that holds 16 bits, in a cycle when that buffer is not read, is dropped. `trib_err[i]` is then high for one cycle.
- R11: A read slot that meets a primed, empty buffer sends 0, pulses `trib_err[i]` for one cycle and returns the buffer to the unprimed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_en | input | 1 | Aggregate bit enable; one aggregate bit per high cycle |
| trib_valid | input | 4 | Per-tributary write strobe |
| trib_data | input | 4 | Per-tributary data bit |
| alarm_in | input | 1 | Remote alarm bit to send |
| nat_in | input | 1 | National bit to send |
| idle_set | input | 1 | Pulse that latches `idle_cmd` |
| idle_cmd | input | 3 | Idle/unframed output code |
| fas_set | input | 1 | Pulse that latches `fas_bad` |
| fas_bad | input | 1 | 1 selects the corrupted alignment word |
| rch_en | input | 1 | Remote channel enable, sampled at frame start |
| rch_data | input | 4 | Remote channel nibble, sampled at frame start |
| frame_start | output | 1 | High while the first alignment bit is presented |
| trib_err | output | 4 | One-cycle buffer overflow/underflow pulse per tributary |
| agg_data | output | 1 | Serial aggregate output |

## Verification
The hardest situation to reach is a primed buffer that is empty at the moment its read slot comes up, followed by re-priming. Reaching it needs a tributary that writes more slowly than the frame drains it, even with the one justification bit per frame that helps it. The bench writes one tributary at about 21.5% of cycles against a drain of about 24.2% and later stops that tributary's writes completely. Overflow at a full buffer is reached two ways: with a tributary that writes too fast, and during framed idle, when no reads happen while writes continue. The bench also exercises a remote-channel change in mid-frame, which must not affect the current frame.

// File: rtl/jm_pkg.sv
package jm_pkg;

    localparam int unsigned N_TRIB    = 4;
    localparam int unsigned TRIB_W    = $clog2(N_TRIB);
    localparam int unsigned SET_LEN   = 212;
    localparam int unsigned FRAME_LEN = 4 * SET_LEN;
    localparam int unsigned POS_W     = $clog2(FRAME_LEN);
    localparam int unsigned ALIGN_LEN = 10;
    localparam int unsigned AIDX_W    = $clog2(ALIGN_LEN);
    localparam logic [ALIGN_LEN-1:0] ALIGN_WORD = 10'b1111010000;

    localparam logic [2:0] IDLE_F0 = 3'd1;
    localparam logic [2:0] IDLE_F1 = 3'd2;
    localparam logic [2:0] IDLE_U0 = 3'd3;
    localparam logic [2:0] IDLE_U1 = 3'd4;

    typedef enum logic [2:0] {
        SK_ALIGN,
        SK_ALARM,
        SK_NAT,
        SK_CJ_FIRST,
        SK_CJ,
        SK_JOPP,
        SK_INFO
    } slot_e;

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [N_TRIB-1:0] just;
        logic              rch;
        logic [N_TRIB-1:0] rdat;
        logic [2:0]        idle;
        logic              fasbad;
        logic              agg;
        logic              fs;
    } frm_state_t;

endpackage

// File: rtl/jm_slot_map.sv
module jm_slot_map
    import jm_pkg::*;
(
    input  logic [POS_W-1:0]  pos,
    output slot_e             kind,
    output logic [AIDX_W-1:0] align_idx
);

    localparam int unsigned CJ1_AT = SET_LEN;
    localparam int unsigned CJ2_AT = 2 * SET_LEN;
    localparam int unsigned CJ3_AT = 3 * SET_LEN;
    localparam int unsigned JO_AT  = CJ3_AT + N_TRIB;

    function automatic logic in_win(input logic [POS_W-1:0] p, input int unsigned base);
        return (p >= POS_W'(base)) && (p < POS_W'(base + N_TRIB));
    endfunction

    always_comb begin
        align_idx = pos[AIDX_W-1:0];
        if (pos < POS_W'(ALIGN_LEN)) begin
            kind = SK_ALIGN;
        end else if (pos == POS_W'(ALIGN_LEN)) begin
            kind = SK_ALARM;
        end else if (pos == POS_W'(ALIGN_LEN + 1)) begin
            kind = SK_NAT;
        end else if (in_win(pos, CJ1_AT)) begin
            kind = SK_CJ_FIRST;
        end else if (in_win(pos, CJ2_AT) || in_win(pos, CJ3_AT)) begin
            kind = SK_CJ;
        end else if (in_win(pos, JO_AT)) begin
            kind = SK_JOPP;
        end else begin
            kind = SK_INFO;
        end
    end

endmodule

// File: rtl/jm_elastic.sv
module jm_elastic #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned PRIME = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_bit,
    input  logic                       rd_req,
    output logic                       rd_bit,
    output logic [$clog2(DEPTH+1)-1:0] fill,
    output logic                       err
);

    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
        logic             primed;
        logic             err;
    } eb_state_t;

    eb_state_t st_d, st_q;
    logic      mem [DEPTH];
    logic      take, uflow, oflow, wr_ok, full;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d  = st_q;
        full  = (st_q.cnt == CNT_W'(DEPTH));
        take  = rd_req && st_q.primed && (st_q.cnt != '0);
        uflow = rd_req && st_q.primed && (st_q.cnt == '0);
        wr_ok = wr_en && (!full || take);
        oflow = wr_en && !wr_ok;

        if (wr_ok) st_d.wptr = bump(st_q.wptr);
        if (take)  st_d.rptr = bump(st_q.rptr);
        case ({wr_ok, take})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        st_d.primed = st_q.primed ? !uflow : (st_q.cnt >= CNT_W'(PRIME));
        st_d.err    = oflow || uflow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[st_q.wptr] <= wr_bit;
    end

    assign rd_bit = take ? mem[st_q.rptr] : 1'b0;
    assign fill   = st_q.cnt;
    assign err    = st_q.err;

endmodule

// File: rtl/trib_jmux.sv
module trib_jmux
    import jm_pkg::*;
#(
    parameter int unsigned BUF_DEPTH = 16,
    parameter int unsigned BUF_PRIME = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic [N_TRIB-1:0] trib_valid,
    input  logic [N_TRIB-1:0] trib_data,
    input  logic              alarm_in,
    input  logic              nat_in,
    input  logic              idle_set,
    input  logic [2:0]        idle_cmd,
    input  logic              fas_set,
    input  logic              fas_bad,
    input  logic              rch_en,
    input  logic [N_TRIB-1:0] rch_data,
    output logic              frame_start,
    output logic [N_TRIB-1:0] trib_err,
    output logic              agg_data
);

    localparam int unsigned CNT_W   = $clog2(BUF_DEPTH + 1);
    localparam int unsigned LOW_LIM = BUF_DEPTH / 2;

    frm_state_t          st_d, st_q;
    slot_e               kind;
    logic [AIDX_W-1:0]   align_idx;
    logic [TRIB_W-1:0]   idx;
    logic [N_TRIB-1:0]   rd_req;
    logic [N_TRIB-1:0]   rd_bit;
    logic [CNT_W-1:0]    fill [N_TRIB];
    logic                framed_idle, unframed, idle_val, normal, pay, bit_out;

    jm_slot_map u_map (
        .pos       (st_q.pos),
        .kind      (kind),
        .align_idx (align_idx)
    );

    for (genvar g = 0; g < N_TRIB; g++) begin : g_buf
        jm_elastic #(
            .DEPTH (BUF_DEPTH),
            .PRIME (BUF_PRIME)
        ) u_eb (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (trib_valid[g]),
            .wr_bit (trib_data[g]),
            .rd_req (rd_req[g]),
            .rd_bit (rd_bit[g]),
            .fill   (fill[g]),
            .err    (trib_err[g])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.fs     = 1'b0;
        rd_req      = '0;
        idx         = st_q.pos[TRIB_W-1:0];
        framed_idle = (st_q.idle == IDLE_F0) || (st_q.idle == IDLE_F1);
        unframed    = (st_q.idle == IDLE_U0) || (st_q.idle == IDLE_U1);
        idle_val    = (st_q.idle == IDLE_F1) || (st_q.idle == IDLE_U1);
        normal      = !framed_idle && !unframed;
        pay         = framed_idle ? idle_val : rd_bit[idx];
        bit_out     = 1'b0;

        if (ref_en) begin
            case (kind)
                SK_ALIGN:    bit_out = ALIGN_WORD[AIDX_W'(ALIGN_LEN - 1) - align_idx] ^ st_q.fasbad;
                SK_ALARM:    bit_out = alarm_in;
                SK_NAT:      bit_out = nat_in;
                SK_CJ_FIRST: bit_out = st_q.rch ? st_q.rdat[idx] : st_q.just[idx];
                SK_CJ:       bit_out = st_q.just[idx];
                SK_JOPP: begin
                    if (framed_idle) begin
                        bit_out = idle_val;
                    end else if (!st_q.just[idx]) begin
                        rd_req[idx] = normal;
                        bit_out     = pay;
                    end
                end
                default: begin
                    rd_req[idx] = normal;
                    bit_out     = pay;
                end
            endcase
            if (unframed) bit_out = idle_val;

            st_d.agg = bit_out;
            st_d.fs  = (st_q.pos == '0);
            st_d.pos = (st_q.pos == POS_W'(FRAME_LEN - 1)) ? '0 : st_q.pos + 1'b1;

            if (st_q.pos == '0) begin
                for (int i = 0; i < N_TRIB; i++) begin
                    st_d.just[i] = (fill[i] < CNT_W'(LOW_LIM));
                end
                st_d.rch  = rch_en;
                st_d.rdat = rch_data;
            end
        end

        if (idle_set) st_d.idle   = idle_cmd;
        if (fas_set)  st_d.fasbad = fas_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign agg_data    = st_q.agg;
    assign frame_start = st_q.fs;

endmodule

// File: rtl/jm_chk.sv
module jm_chk
    import jm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ref_en,
    input logic [N_TRIB-1:0] trib_valid,
    input logic              idle_set,
    input logic [2:0]        idle_cmd,
    input logic              frame_start,
    input logic [N_TRIB-1:0] trib_err,
    input logic              agg_data
);

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R2

    AST_FS_FROM_EN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $past(ref_en)); // R2

    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en |=> $stable(agg_data)); // R2

    AST_UNFRAMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_set && idle_cmd == IDLE_U0) ##1 ref_en |=> !agg_data); // R7

    AST_UNFRAMED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_set && idle_cmd == IDLE_U1) ##1 ref_en |=> agg_data); // R7

    for (genvar g = 0; g < N_TRIB; g++) begin : g_err
        AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            trib_err[g] |-> $past(trib_valid[g] || ref_en)); // R10 R11
    end

endmodule

bind trib_jmux jm_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_en      (ref_en),
    .trib_valid  (trib_valid),
    .idle_set    (idle_set),
    .idle_cmd    (idle_cmd),
    .frame_start (frame_start),
    .trib_err    (trib_err),
    .agg_data    (agg_data)
);

// File: tb/trib_jmux_tb.sv
module trib_jmux_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_en = 1'b0;
    logic [3:0] trib_valid = '0;
    logic [3:0] trib_data = '0;
    logic       alarm_in = 1'b0;
    logic       nat_in = 1'b0;
    logic       idle_set = 1'b0;
    logic [2:0] idle_cmd = '0;
    logic       fas_set = 1'b0;
    logic       fas_bad = 1'b0;
    logic       rch_en = 1'b0;
    logic [3:0] rch_data = '0;
    logic       frame_start;
    logic [3:0] trib_err;
    logic       agg_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit cmp_on  = 0;
    bit done    = 0;

    int en_pct  = 100;
    int wr_pm [4] = '{275, 215, 242, 245};

    // reference model state
    int       mpos;
    bit       mjust [4];
    bit       mrch;
    bit [3:0] mrdat;
    bit [2:0] midle;
    bit       mfas;
    bit       mprimed [4];
    bit       q [4][$];
    bit       exp_data, exp_fs;
    bit [3:0] exp_err;
    string    exp_tag;
    string    err_tag [4];

    trib_jmux u_dut (
        .clk (clk), .rst_n (rst_n), .ref_en (ref_en),
        .trib_valid (trib_valid), .trib_data (trib_data),
        .alarm_in (alarm_in), .nat_in (nat_in),
        .idle_set (idle_set), .idle_cmd (idle_cmd),
        .fas_set (fas_set), .fas_bad (fas_bad),
        .rch_en (rch_en), .rch_data (rch_data),
        .frame_start (frame_start), .trib_err (trib_err), .agg_data (agg_data)
    );

    always #10 clk = ~clk;

    // 0 align, 1 alarm, 2 national, 3 first control copy, 4 control, 5 opportunity, 6 information
    function automatic int kind_of(int p);
        if (p < 10) return 0;
        if (p == 10) return 1;
        if (p == 11) return 2;
        if (p >= 212 && p <= 215) return 3;
        if ((p >= 424 && p <= 427) || (p >= 636 && p <= 639)) return 4;
        if (p >= 640 && p <= 643) return 5;
        return 6;
    endfunction

    task automatic check(input bit act, input bit expv, input string tag, input string what);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d pos=%0d t=%0t", tag, what, act, expv, mpos, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mpos = 0; mrch = 0; mrdat = 0; midle = 0; mfas = 0;
            exp_data = 0; exp_fs = 0; exp_err = 0; exp_tag = "R1";
            for (int i = 0; i < 4; i++) begin
                mjust[i] = 0; mprimed[i] = 0; q[i].delete(); err_tag[i] = "R1";
            end
        end else begin
            bit       fr_idle, unfr, ival, normal, b, upd;
            bit [3:0] rdr, tk, tbit, uf, blk;
            bit       nj [4];
            int       k, ix, sz;
            bit       wr_ok, of;
            fr_idle = (midle == 1) || (midle == 2);
            unfr    = (midle == 3) || (midle == 4);
            ival    = (midle == 2) || (midle == 4);
            normal  = !fr_idle && !unfr;
            rdr = 0; tk = 0; tbit = 0; uf = 0; blk = 0; upd = 0; b = 0;
            k = kind_of(mpos); ix = mpos % 4;
            exp_fs = 0; exp_err = 0;
            if (ref_en) begin
                if (normal && (k == 6 || (k == 5 && !mjust[ix]))) rdr[ix] = 1;
                if (mpos == 0) begin
                    upd = 1;
                    for (int i = 0; i < 4; i++) nj[i] = (q[i].size() < 8);
                end
            end
            for (int i = 0; i < 4; i++) begin
                sz    = q[i].size();
                uf[i] = rdr[i] && mprimed[i] && sz == 0;
                tk[i] = rdr[i] && mprimed[i] && sz > 0;
                blk[i] = rdr[i] && !mprimed[i];
                wr_ok = trib_valid[i] && (sz < 16 || tk[i]);
                of    = trib_valid[i] && !wr_ok;
                mprimed[i] = mprimed[i] ? !uf[i] : (sz >= 4);
                if (tk[i]) tbit[i] = q[i].pop_front();
                if (wr_ok) q[i].push_back(trib_data[i]);
                exp_err[i] = of || uf[i];
                err_tag[i] = uf[i] ? "R11" : "R10";
            end
            if (ref_en) begin
                case (k)
                    0: begin b = (mpos < 4 || mpos == 5) ? 1'b1 : 1'b0; b = b ^ mfas; exp_tag = mfas ? "R8" : "R3"; end
                    1: begin b = alarm_in; exp_tag = "R3"; end
                    2: begin b = nat_in; exp_tag = "R3"; end
                    3: begin b = mrch ? mrdat[ix] : mjust[ix]; exp_tag = mrch ? "R6" : "R5"; end
                    4: begin b = mjust[ix]; exp_tag = "R5"; end
                    default: begin
                        if (fr_idle) begin b = ival; exp_tag = "R7"; end
                        else if (k == 5 && mjust[ix]) begin b = 0; exp_tag = "R5"; end
                        else begin
                            b = tbit[ix];
                            exp_tag = uf[ix] ? "R11" : (blk[ix] ? "R9" : "R4");
                        end
                    end
                endcase
                if (unfr) begin b = ival; exp_tag = "R7"; end
                exp_data = b;
                exp_fs   = (mpos == 0);
                mpos     = (mpos + 1) % 848;
                if (upd) begin
                    for (int i = 0; i < 4; i++) mjust[i] = nj[i];
                    mrch = rch_en; mrdat = rch_data;
                end
            end else begin
                exp_tag = "R2";
            end
            if (idle_set) midle = idle_cmd;
            if (fas_set)  mfas  = fas_bad;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(agg_data, exp_data, exp_tag, "agg_data");
            check(frame_start, exp_fs, "R2", "frame_start");
            for (int i = 0; i < 4; i++) check(trib_err[i], exp_err[i], err_tag[i], "trib_err");
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            ref_en   = ($urandom_range(99) < en_pct);
            alarm_in = $urandom_range(1);
            nat_in   = $urandom_range(1);
            for (int i = 0; i < 4; i++) begin
                trib_valid[i] = ($urandom_range(999) < wr_pm[i]);
                trib_data[i]  = $urandom_range(1);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL R2 watchdog act=%0d exp<190000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic run_frames(input int n);
        repeat (n * 848) @(negedge clk);
    endtask

    task automatic set_idle(input bit [2:0] code);
        @(negedge clk); idle_cmd = code; idle_set = 1;
        @(negedge clk); idle_set = 0;
    endtask

    task automatic set_fas(input bit bad);
        @(negedge clk); fas_bad = bad; fas_set = 1;
        @(negedge clk); fas_set = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state at the ports
        check(agg_data, 1'b0, "R1", "agg_data in reset");
        check(frame_start, 1'b0, "R1", "frame_start in reset");
        for (int i = 0; i < 4; i++) check(trib_err[i], 1'b0, "R1", "trib_err in reset");
        rst_n  = 1;
        cmp_on = 1;

        // R4 R5 R9 R10 R11: free-running tributaries, fast and slow ones
        run_frames(6);

        // R2: gapped reference enable
        en_pct = 75;
        wr_pm  = '{185, 180, 182, 184};
        run_frames(4);
        en_pct = 100;
        wr_pm  = '{242, 240, 243, 244};

        // R6: remote channel, nibble changed mid-frame
        rch_en = 1; rch_data = 4'b1010;
        run_frames(1);
        repeat (400) @(negedge clk);
        rch_data = 4'b0101;
        run_frames(2);
        rch_en = 0;

        // R8: corrupted alignment word, then restored
        set_fas(1);
        run_frames(2);
        set_fas(0);
        run_frames(1);

        // R7: idle codes; writes continue so buffers overflow (R10)
        set_idle(3'd1); run_frames(1);
        set_idle(3'd2); run_frames(1);
        set_idle(3'd3); run_frames(1);
        set_idle(3'd4); run_frames(1);
        set_idle(3'd6); run_frames(1);
        set_idle(3'd0);

        // R11 then R9: starve tributary 1, then resume
        wr_pm = '{242, 0, 243, 244};
        run_frames(2);
        wr_pm = '{242, 300, 243, 244};
        run_frames(2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule